// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a single configurable output cell of a programmable logic array. Its data input is a sum of products: the OR of whichever product-term inputs the configuration enables. A static configuration then chooses how that value is stored. It can pass straight through, be captured by an edge-triggered D or T flip-flop, or be held in a level-sensitive latch. The storage is triggered by one of two global clocks, and an optional inversion is applied at the output.

The cell drives a pin value with an output enable and a separate feedback value into the interconnect. A parameter selects one of two variants. The pin-facing variant can leave its pin undriven, so that the pin serves as an input, and still keep its storage in use through feedback. The buried variant never drives a pin. It can instead capture the pin of a neighbouring cell as an input register.

Top module: `logicCell`

## Requirements
- R1: The cell data is the OR of `termVec[i]` over every i whose `termUse[i]` is 1; with no term enabled the data is 0.
- R2: With `cfgMode` = 0 (pass-through) the cell output follows the data combinationally, with no clock edge needed.
- R3: With `cfgMode` = 1 (D flip-flop) the cell output takes the data value on each rising edge of the selected clock and holds it otherwise.
- R4: With `cfgMode` = 2 (T flip-flop) the stored bit inverts on a rising edge of the selected clock when the data is 1 and holds when the data is 0.
- R5: With `cfgMode` = 3 (latch) the stored bit follows the data while the selected clock is high and holds while it is low.
- R6: `cfgClkSel` = 0 selects `gClk0` and 1 selects `gClk1`; edges of the unselected clock do not change the stored bit.
- R7: `cfgInvert` = 1 inverts the cell value after the storage/bypass choice, on both `pinOut` and `fbOut`.
- R8: `rstN` low clears the flip-flop and the latch to 0 at once, without a clock, so that in any storing mode the output equals `cfgInvert`.
- R9: In the pin variant (`IS_BURIED` = 0), `pinOe` equals `cfgPinDrive` and `pinOut` equals the cell output while driven, else 0. `fbOut` carries the cell output in both cases.
- R10: In the buried variant (`IS_BURIED` = 1), `pinOe` and `pinOut` are always 0 and `fbOut` always carries the cell output.
- R11: In the buried variant with `cfgInReg` = 1, the data comes from `nbrPin` instead of the product terms, and mode 2 stores like mode 1. The pin variant ignores `cfgInReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gClk0 | input | 1 | Global clock 0 |
| gClk1 | input | 1 | Global clock 1 |
| rstN | input | 1 | Asynchronous active-low clear of stored state |
| termVec | input | NUM_TERMS | Product-term values |
| termUse | input | NUM_TERMS | Per-term enable into the OR |
| nbrPin | input | 1 | Neighbouring pin value for input-register use |
| cfgMode | input | 2 | Storage mode: 0 pass, 1 D, 2 T, 3 latch |
| cfgClkSel | input | 1 | Clock select: 0 gClk0, 1 gClk1 |
| cfgInvert | input | 1 | Output polarity inversion |
| cfgPinDrive | input | 1 | Drive the pin (pin variant only) |
| cfgInReg | input | 1 | Take data from nbrPin (buried variant only) |
| pinOut | output | 1 | Pin output value |
| pinOe | output | 1 | Pin output enable |
| fbOut | output | 1 | Feedback value into the interconnect |

## Verification
The bench builds two copies side by side with the default 16 terms, one with `IS_BURIED` = 0 and one with `IS_BURIED` = 1, and drives both from the same inputs. The full term width lets the lowest and highest term positions and the masking of disabled terms be exercised. Running both variants together shows, in the same cycle, that the pin variant ignores the input-register setting while the buried variant takes its data from the neighbouring pin. A second clock held under direct bench control makes it possible to check that edges on the unselected clock are ignored.

// File: rtl/logicCellPkg.sv
`timescale 1ns/1ps
package logicCellPkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_DFF   = 2'd1,
    MODE_TFF   = 2'd2,
    MODE_LATCH = 2'd3
  } cellMode_e;

  // Decoded strobes from control to datapath
  typedef struct packed {
    logic useFlop;
    logic useLatch;
    logic toggleEn;
    logic fromPin;
    logic invert;
    logic clkSel;
    logic drivePin;
  } cellStrobe_t;

endpackage

// File: rtl/logicCellCtrl.sv
`timescale 1ns/1ps
module logicCellCtrl
  import logicCellPkg::*;
#(
  parameter bit IS_BURIED = 1'b0
) (
  input  logic [1:0]  cfgMode,
  input  logic        cfgClkSel,
  input  logic        cfgInvert,
  input  logic        cfgPinDrive,
  input  logic        cfgInReg,
  output cellStrobe_t strobe
);

  cellMode_e modeDec;
  logic      pinSource;

  always_comb begin
    modeDec   = cellMode_e'(cfgMode);
    pinSource = IS_BURIED && cfgInReg;

    strobe.fromPin  = pinSource;
    strobe.useFlop  = (modeDec == MODE_DFF) || (modeDec == MODE_TFF);
    strobe.useLatch = (modeDec == MODE_LATCH);
    // an input register only captures, never toggles
    strobe.toggleEn = (modeDec == MODE_TFF) && !pinSource;
    strobe.invert   = cfgInvert;
    strobe.clkSel   = cfgClkSel;
    strobe.drivePin = !IS_BURIED && cfgPinDrive;
  end

endmodule

// File: rtl/logicCellPath.sv
`timescale 1ns/1ps
module logicCellPath
  import logicCellPkg::*;
#(
  parameter int NUM_TERMS = 16,
  parameter bit IS_BURIED = 1'b0
) (
  input  logic                 gClk0,
  input  logic                 gClk1,
  input  logic                 rstN,
  input  logic [NUM_TERMS-1:0] termVec,
  input  logic [NUM_TERMS-1:0] termUse,
  input  logic                 nbrPin,
  input  cellStrobe_t          strobe,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbOut
);

  localparam int LAST_TERM = NUM_TERMS - 1;

  logic [LAST_TERM:0] gatedTerm;
  logic sumOfProducts;
  logic dataIn;
  logic selClk;
  logic flopQ;
  logic latchQ;
  logic cellVal;
  logic outVal;

  // per-term gating, then OR reduction
  for (genvar t = 0; t < NUM_TERMS; t++) begin : gTerm
    assign gatedTerm[t] = termVec[t] & termUse[t];
  end
  assign sumOfProducts = |gatedTerm;

  assign dataIn = strobe.fromPin ? nbrPin : sumOfProducts;
  assign selClk = strobe.clkSel ? gClk1 : gClk0;

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN)
      flopQ <= 1'b0;
    else if (strobe.useFlop)
      flopQ <= strobe.toggleEn ? (flopQ ^ dataIn) : dataIn;
  end

  always_latch begin
    if (!rstN)
      latchQ = 1'b0;
    else if (selClk && strobe.useLatch)
      latchQ = dataIn;
  end

  always_comb begin
    if (strobe.useFlop)
      cellVal = flopQ;
    else if (strobe.useLatch)
      cellVal = latchQ;
    else
      cellVal = dataIn;
  end

  assign outVal = cellVal ^ strobe.invert;
  assign fbOut  = outVal;

  if (IS_BURIED) begin : gBuried
    assign pinOut = 1'b0;
    assign pinOe  = 1'b0;
  end else begin : gPinCell
    assign pinOe  = strobe.drivePin;
    assign pinOut = strobe.drivePin ? outVal : 1'b0;
  end

endmodule

// File: rtl/logicCell.sv
`timescale 1ns/1ps
module logicCell
  import logicCellPkg::*;
#(
  parameter int NUM_TERMS = 16,
  parameter bit IS_BURIED = 1'b0
) (
  input  logic                 gClk0,
  input  logic                 gClk1,
  input  logic                 rstN,
  input  logic [NUM_TERMS-1:0] termVec,
  input  logic [NUM_TERMS-1:0] termUse,
  input  logic                 nbrPin,
  input  logic [1:0]           cfgMode,
  input  logic                 cfgClkSel,
  input  logic                 cfgInvert,
  input  logic                 cfgPinDrive,
  input  logic                 cfgInReg,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbOut
);

  cellStrobe_t strobe;

  logicCellCtrl #(.IS_BURIED(IS_BURIED)) ctrl (
    .cfgMode     (cfgMode),
    .cfgClkSel   (cfgClkSel),
    .cfgInvert   (cfgInvert),
    .cfgPinDrive (cfgPinDrive),
    .cfgInReg    (cfgInReg),
    .strobe      (strobe)
  );

  logicCellPath #(.NUM_TERMS(NUM_TERMS), .IS_BURIED(IS_BURIED)) path (
    .gClk0   (gClk0),
    .gClk1   (gClk1),
    .rstN    (rstN),
    .termVec (termVec),
    .termUse (termUse),
    .nbrPin  (nbrPin),
    .strobe  (strobe),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .fbOut   (fbOut)
  );

endmodule

// File: rtl/logicCellChecker.sv
`timescale 1ns/1ps
module logicCellChecker #(
  parameter int NUM_TERMS = 16,
  parameter bit IS_BURIED = 1'b0
) (
  input logic                 gClk0,
  input logic                 rstN,
  input logic [NUM_TERMS-1:0] termVec,
  input logic [NUM_TERMS-1:0] termUse,
  input logic [1:0]           cfgMode,
  input logic                 cfgClkSel,
  input logic                 cfgInvert,
  input logic                 cfgPinDrive,
  input logic                 cfgInReg,
  input logic                 pinOut,
  input logic                 pinOe,
  input logic                 fbOut
);

  logic termData;
  logic termSourced;
  assign termData    = |(termVec & termUse);
  assign termSourced = !IS_BURIED || !cfgInReg;

  assert_dff_capture_R3: assert property (@(posedge gClk0) disable iff (!rstN)
    (cfgMode == 2'd1 && !cfgClkSel && termSourced)
    |=> (cfgMode != 2'd1 || cfgClkSel || fbOut == ($past(termData) ^ cfgInvert)))
    else $error("D capture mismatch");

  assert_tff_toggle_R4: assert property (@(posedge gClk0) disable iff (!rstN)
    (cfgMode == 2'd2 && !cfgClkSel && termSourced && termData)
    |=> (cfgMode != 2'd2 || cfgClkSel || cfgInvert != $past(cfgInvert) || fbOut != $past(fbOut)))
    else $error("T toggle missing");

  assert_latch_follow_R5: assert property (@(negedge gClk0) disable iff (!rstN)
    (cfgMode == 2'd3 && !cfgClkSel && termSourced) |-> (fbOut == (termData ^ cfgInvert)))
    else $error("latch did not follow data");

  always @(negedge gClk0) begin
    if (!rstN && cfgMode != 2'd0) begin
      assert_reset_clear_R8: assert (fbOut == cfgInvert) else $error("reset did not clear");
    end
    if (IS_BURIED) begin
      assert_buried_pin_quiet_R10: assert (!pinOe && !pinOut) else $error("buried cell drove pin");
    end else begin
      assert_pin_enable_R9: assert (pinOe == cfgPinDrive) else $error("pin enable mismatch");
      assert_pin_matches_fb_R9: assert (!pinOe || pinOut == fbOut) else $error("pin differs from feedback");
    end
  end

endmodule

bind logicCell logicCellChecker #(.NUM_TERMS(NUM_TERMS), .IS_BURIED(IS_BURIED)) chk (
  .gClk0       (gClk0),
  .rstN        (rstN),
  .termVec     (termVec),
  .termUse     (termUse),
  .cfgMode     (cfgMode),
  .cfgClkSel   (cfgClkSel),
  .cfgInvert   (cfgInvert),
  .cfgPinDrive (cfgPinDrive),
  .cfgInReg    (cfgInReg),
  .pinOut      (pinOut),
  .pinOe       (pinOe),
  .fbOut       (fbOut)
);

// File: tb/logicCell_test.sv
`timescale 1ns/1ps
module logicCell_test;

  localparam int NT = 16;

  logic clk = 1'b0;
  logic gClk1 = 1'b0;
  logic rstN = 1'b0;
  logic [NT-1:0] termVec = '0;
  logic [NT-1:0] termUse = '0;
  logic nbrPin = 1'b0;
  logic [1:0] cfgMode = 2'd1;
  logic cfgClkSel = 1'b0;
  logic cfgInvert = 1'b0;
  logic cfgPinDrive = 1'b1;
  logic cfgInReg = 1'b0;
  logic pinOut, pinOe, fbOut;
  logic bPinOut, bPinOe, bFbOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  logicCell #(.NUM_TERMS(NT), .IS_BURIED(1'b0)) uut (
    .gClk0(clk), .gClk1(gClk1), .rstN(rstN), .termVec(termVec), .termUse(termUse),
    .nbrPin(nbrPin), .cfgMode(cfgMode), .cfgClkSel(cfgClkSel), .cfgInvert(cfgInvert),
    .cfgPinDrive(cfgPinDrive), .cfgInReg(cfgInReg),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut));

  logicCell #(.NUM_TERMS(NT), .IS_BURIED(1'b1)) uutBuried (
    .gClk0(clk), .gClk1(gClk1), .rstN(rstN), .termVec(termVec), .termUse(termUse),
    .nbrPin(nbrPin), .cfgMode(cfgMode), .cfgClkSel(cfgClkSel), .cfgInvert(cfgInvert),
    .cfgPinDrive(cfgPinDrive), .cfgInReg(cfgInReg),
    .pinOut(bPinOut), .pinOe(bPinOe), .fbOut(bFbOut));

  typedef struct packed {
    logic [1:0]    mode;
    logic          sel;
    logic          inv;
    logic [NT-1:0] mask;
    logic [NT-1:0] terms;
    logic          expFb;
  } step_t;

  // Each row: applied with clk low, one gClk0 cycle, then checked.
  localparam int NSTEPS = 16;
  localparam step_t STEPS [NSTEPS] = '{
    '{2'd0, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 1'b0},  // R1 no terms
    '{2'd0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b1},  // R7 invert
    '{2'd0, 1'b0, 1'b0, 16'h0010, 16'h0010, 1'b1},  // R2 pass
    '{2'd1, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1},  // R3 capture 1
    '{2'd1, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0},  // R3 capture 0
    '{2'd1, 1'b0, 1'b1, 16'h8000, 16'h8000, 1'b0},  // R7 top term, inverted
    '{2'd1, 1'b1, 1'b0, 16'h0001, 16'h0000, 1'b1},  // R6 gClk1 idle holds 1
    '{2'd2, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b0},  // R4 toggle 1->0
    '{2'd2, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1},  // R4 toggle 0->1
    '{2'd2, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b1},  // R4 hold
    '{2'd2, 1'b0, 1'b1, 16'h0001, 16'h0001, 1'b1},  // R4 toggle to 0, inverted
    '{2'd3, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1},  // R5 transparent
    '{2'd3, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0},  // R5 transparent 0
    '{2'd3, 1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0},  // R6 latch on idle gClk1 holds
    '{2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0100, 1'b1},  // R2 pass, middle term
    '{2'd1, 1'b0, 1'b0, 16'h00F0, 16'h000F, 1'b0}   // R1 disabled terms masked
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setCfg(input logic [1:0] m, input logic s, input logic i,
                        input logic [NT-1:0] mk, input logic [NT-1:0] tv);
    cfgMode = m; cfgClkSel = s; cfgInvert = i; termUse = mk; termVec = tv;
  endtask

  // wait to next negedge + 0.5 (sample point)
  task automatic toSample();
    @(negedge clk); #0.5;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    // reset state, R8
    toSample();
    check("R8 reset fb", fbOut, 1'b0);
    check("R8 reset buried fb", bFbOut, 1'b0);
    check("R9 reset pinOe", pinOe, 1'b1);
    check("R10 buried pinOe", bPinOe, 1'b0);
    #0.5;
    cfgInvert = 1'b1;
    toSample();
    check("R8 reset fb inverted", fbOut, 1'b1);
    #0.5;
    cfgInvert = 1'b0;
    rstN = 1'b1;

    // table walk
    for (int k = 0; k < NSTEPS; k++) begin
      setCfg(STEPS[k].mode, STEPS[k].sel, STEPS[k].inv, STEPS[k].mask, STEPS[k].terms);
      toSample();
      check($sformatf("R1-table step %0d fb", k), fbOut, STEPS[k].expFb);
      check($sformatf("R10 step %0d buried fb", k), bFbOut, STEPS[k].expFb);
      check($sformatf("R9 step %0d pinOut", k), pinOut, STEPS[k].expFb);
      check($sformatf("R10 step %0d buried pin", k), bPinOut | bPinOe, 1'b0);
      #0.5;
    end

    // R8: async clear mid-run
    setCfg(2'd1, 1'b0, 1'b0, 16'h0001, 16'h0001);
    toSample();
    check("R3 set before clear", fbOut, 1'b1);
    #0.5;
    rstN = 1'b0;
    #0.5;
    check("R8 async clear fb", fbOut, 1'b0);
    check("R8 async clear pinOut", pinOut, 1'b0);
    check("R8 async clear buried", bFbOut, 1'b0);
    @(negedge clk); #1;
    rstN = 1'b1;

    // R6: gClk1 drives D capture, gClk0 ignored
    setCfg(2'd1, 1'b1, 1'b0, 16'h0001, 16'h0001);
    #0.5 gClk1 = 1'b1;
    #0.5 gClk1 = 1'b0;
    #0.2;
    check("R6 gClk1 edge captured", fbOut, 1'b1);
    termVec = '0;
    toSample();
    check("R6 gClk0 edge ignored", fbOut, 1'b1);
    #0.5;

    // R5: latch on gClk1, transparent high, hold low
    setCfg(2'd3, 1'b1, 1'b0, 16'h0001, 16'h0001);
    #0.2;
    check("R5 latch closed holds", fbOut, 1'b0);
    gClk1 = 1'b1;
    #0.2;
    check("R5 latch open follows 1", fbOut, 1'b1);
    termVec = '0;
    #0.2;
    check("R5 latch open follows 0", fbOut, 1'b0);
    gClk1 = 1'b0;
    #0.1;
    termVec = 16'h0001;
    #0.1;
    check("R5 latch closed ignores data", fbOut, 1'b0);
    @(negedge clk); #1;

    // R9: pin undriven, feedback still live
    cfgPinDrive = 1'b0;
    setCfg(2'd0, 1'b0, 1'b0, 16'h0001, 16'h0001);
    toSample();
    check("R9 undriven pinOe", pinOe, 1'b0);
    check("R9 undriven pinOut", pinOut, 1'b0);
    check("R9 undriven fb", fbOut, 1'b1);
    #0.5;
    cfgPinDrive = 1'b1;

    // R11: buried input register from nbrPin
    cfgInReg = 1'b1;
    nbrPin = 1'b1;
    setCfg(2'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    toSample();
    check("R11 buried captures nbrPin", bFbOut, 1'b1);
    check("R11 pin variant ignores inReg", fbOut, 1'b0);
    #0.5;
    cfgMode = 2'd2;
    toSample();
    check("R11 T acts as D step 1", bFbOut, 1'b1);
    #0.5;
    toSample();
    check("R11 T acts as D step 2", bFbOut, 1'b1);
    #0.5;
    cfgMode = 2'd3;
    nbrPin = 1'b0;
    toSample();
    check("R11 latch input register", bFbOut, 1'b0);
    #0.5;
    cfgInReg = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule